// File: doc/BRIEF.md
# Fine Phase-Step Control Port

This block models the control side of a clock tile's fine phase-adjust port. It runs on its own adjust clock. After reset it waits a fixed settling time and then raises a lock flag. While locked it takes one-cycle step requests. Each request moves the phase of a notional output clock by one unit step, up or down. No analog clock is produced. The block only keeps track of the handshake and of how far the phase has moved in total.

Only one step can be in flight at a time. A request that is accepted starts a fixed twelve-cycle latency. At the end of that latency a one-cycle done pulse appears, and the running step count is updated in the same cycle. Requests that arrive while a step is still in flight are dropped without any trace. A busy flag shows when a step is pending. The count is also given as a signed offset in picoseconds, at 18 ps per unit step.

Top module: `fine_phase_port`

## Requirements
- R1: While `rst` is high, `lockOk`, `busy` and `stepDone` are 0, and `stepCount` and `offsetPs` are 0. Asserting reset cancels a pending step, so no done pulse follows it.
- R2: Count the first rising edge that samples `rst` low as edge 1. `lockOk` rises right after edge 16 and then stays high until the next reset.
- R3: A request is `stepReq` high at a rising edge where `lockOk` is 1 and `busy` is 0. Such a request is accepted. A request at any other time is ignored: `busy` does not rise, no done pulse follows, and the count does not change.
- R4: `stepDone` is high for exactly one cycle. That cycle is 12 cycles after the accepting cycle: if the request was sampled in cycle k, done is high in cycle k+12.
- R5: `stepCount` changes only in the cycle where `stepDone` is high. It moves by +1 if `stepUp` was 1 in the accepting cycle and by -1 if it was 0. Changes to `stepUp` after acceptance have no effect.
- R6: `busy` is 1 from cycle k+1 through cycle k+12 (the done cycle), both included, and is 0 again in cycle k+13.
- R7: Requests made while `busy` is 1, including in the done cycle, are dropped. They do not restart the latency, and they add no done pulse or count change.
- R8: `stepCount` is an 11-bit two's-complement value. It saturates at +1023 and -1024. A step past either limit still gives its done pulse but leaves the count unchanged.
- R9: `offsetPs` equals `stepCount` times 18, as a signed 16-bit two's-complement value. For example, +1023 gives 18414 and -1024 gives -18432.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-adjust clock |
| rst | input | 1 | Synchronous reset, active high |
| stepReq | input | 1 | One-cycle step request |
| stepUp | input | 1 | Direction: 1 increases phase, 0 decreases it |
| stepDone | output | 1 | One-cycle completion pulse |
| lockOk | output | 1 | Output clock considered stable |
| busy | output | 1 | A step is pending |
| stepCount | output | 11 | Signed accumulated unit steps |
| offsetPs | output | 16 | Signed accumulated offset in ps |

## Verification
Some rules are checked by assertions on every cycle:
- The done pulse lasts one cycle.
- The count is frozen outside done cycles and moves by at most one unit within them.
- `busy` stays high until done and clears right after it.
- Nothing becomes pending while unlocked.
- Lock never drops without a reset.

Other behaviour can only be shown by the bench's scenarios:
- The exact twelve-cycle latency and the sixteen-cycle lock delay.
- That a dropped early pulse does not restart the latency.
- That the direction is taken only in the accepting cycle.
- Saturation at both limits.
- Cancellation of a pending step by reset.

// File: rtl/fine_phase_pkg.sv
package fine_phase_pkg;

  // Strobes from control to datapath: apply one step now, in this direction.
  typedef struct packed {
    logic commit;
    logic up;
  } step_strobe_t;

endpackage

// File: rtl/fine_phase_ctrl.sv
module fine_phase_ctrl
  import fine_phase_pkg::*;
#(
  parameter int LATENCY = 12,
  parameter int SETTLE  = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stepReq,
  input  logic         stepUp,
  output logic         lockOk,
  output logic         busy,
  output logic         stepDone,
  output step_strobe_t strobe
);

  localparam int LAT_W = $clog2(LATENCY + 1);
  localparam int SET_W = $clog2(SETTLE + 1);
  localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(LATENCY - 1);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE - 1);

  logic [SET_W-1:0] settleCnt;
  logic [LAT_W-1:0] latCnt;
  logic             dirReg;
  logic             accept;
  logic             commitNow;

  // Lock settling: count cycles since reset release, then latch lock.
  always_ff @(posedge clk) begin
    if (rst) begin
      settleCnt <= '0;
      lockOk    <= 1'b0;
    end else if (!lockOk) begin
      settleCnt <= settleCnt + 1'b1;
      if (settleCnt == SET_LAST) lockOk <= 1'b1;
    end
  end

  // A request is only taken when locked and idle.
  assign accept    = stepReq && lockOk && !busy;
  // Last pending cycle before done: apply the step at this edge.
  assign commitNow = busy && (latCnt == LAT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      latCnt   <= '0;
      dirReg   <= 1'b0;
      stepDone <= 1'b0;
    end else begin
      stepDone <= commitNow;
      if (accept) begin
        busy   <= 1'b1;
        latCnt <= LAT_W'(1);
        dirReg <= stepUp;
      end else if (stepDone) begin
        busy   <= 1'b0;
        latCnt <= '0;
      end else if (busy) begin
        latCnt <= latCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.commit = commitNow;
    strobe.up     = dirReg;
  end

endmodule

// File: rtl/fine_phase_dp.sv
module fine_phase_dp
  import fine_phase_pkg::*;
#(
  parameter int CNT_W   = 11,
  parameter int STEP_PS = 18,
  parameter int PS_W    = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  step_strobe_t            strobe,
  output logic signed [CNT_W-1:0] stepCount,
  output logic signed [PS_W-1:0]  offsetPs
);

  localparam logic signed [CNT_W-1:0] CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic signed [PS_W-1:0]  UNIT_PS = PS_W'(STEP_PS);

  logic signed [PS_W-1:0] wideCount;

  // Saturating step accumulator, updated only on the commit strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      stepCount <= '0;
    end else if (strobe.commit) begin
      if (strobe.up && stepCount != CNT_MAX)
        stepCount <= stepCount + CNT_W'(1);
      else if (!strobe.up && stepCount != CNT_MIN)
        stepCount <= stepCount - CNT_W'(1);
    end
  end

  // Sign-extend and scale to picoseconds.
  always_comb begin
    wideCount = {{(PS_W-CNT_W){stepCount[CNT_W-1]}}, stepCount};
    offsetPs  = wideCount * UNIT_PS;
  end

endmodule

// File: rtl/fine_phase_port.sv
module fine_phase_port
  import fine_phase_pkg::*;
#(
  parameter int LATENCY = 12,
  parameter int SETTLE  = 16,
  parameter int CNT_W   = 11,
  parameter int STEP_PS = 18,
  parameter int PS_W    = CNT_W + $clog2(STEP_PS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    stepReq,
  input  logic                    stepUp,
  output logic                    stepDone,
  output logic                    lockOk,
  output logic                    busy,
  output logic signed [CNT_W-1:0] stepCount,
  output logic signed [PS_W-1:0]  offsetPs
);

  step_strobe_t strobe;

  fine_phase_ctrl #(
    .LATENCY(LATENCY),
    .SETTLE (SETTLE)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .stepReq (stepReq),
    .stepUp  (stepUp),
    .lockOk  (lockOk),
    .busy    (busy),
    .stepDone(stepDone),
    .strobe  (strobe)
  );

  fine_phase_dp #(
    .CNT_W  (CNT_W),
    .STEP_PS(STEP_PS),
    .PS_W   (PS_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .stepCount(stepCount),
    .offsetPs (offsetPs)
  );

endmodule

// File: rtl/fine_phase_port_chk.sv
module fine_phase_port_chk #(
  parameter int CNT_W = 11,
  parameter int PS_W  = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    stepDone,
  input logic                    lockOk,
  input logic                    busy,
  input logic signed [CNT_W-1:0] stepCount,
  input logic signed [PS_W-1:0]  offsetPs
);

  // R4: done is a single-cycle pulse
  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    stepDone |=> !stepDone);

  // R5: count frozen outside done cycles
  a_r5_count_frozen: assert property (@(posedge clk) disable iff (rst)
    (!stepDone && !$past(rst)) |-> $stable(stepCount));

  // R5: at most one unit per done
  a_r5_unit_move: assert property (@(posedge clk) disable iff (rst)
    (stepDone && !$past(rst)) |->
      (stepCount == $past(stepCount)) ||
      (stepCount == $past(stepCount) + CNT_W'(1)) ||
      (stepCount == $past(stepCount) - CNT_W'(1)));

  // R6: busy covers the done cycle
  a_r6_busy_at_done: assert property (@(posedge clk) disable iff (rst)
    stepDone |-> busy);

  // R6: busy holds until done
  a_r6_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && !stepDone) |=> busy);

  // R6: busy clears after done
  a_r6_busy_clears: assert property (@(posedge clk) disable iff (rst)
    stepDone |=> !busy);

  // R3: nothing pending while unlocked
  a_r3_no_accept_unlocked: assert property (@(posedge clk) disable iff (rst)
    !lockOk |=> !busy);

  // R2: lock is sticky until reset
  a_r2_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lockOk |=> lockOk);

endmodule

bind fine_phase_port fine_phase_port_chk #(
  .CNT_W(CNT_W),
  .PS_W (PS_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .stepDone (stepDone),
  .lockOk   (lockOk),
  .busy     (busy),
  .stepCount(stepCount),
  .offsetPs (offsetPs)
);

// File: tb/fine_phase_port_bench.sv
`timescale 1ns / 1ps
module fine_phase_port_bench;

  localparam int LAT    = 12;
  localparam int SETTLE = 16;
  localparam int CNT_W  = 11;
  localparam int PS_W   = 16;
  localparam int UNIT   = 18;
  localparam int CMAX   = 1023;
  localparam int CMIN   = -1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stepReq = 1'b0;
  logic stepUp = 1'b0;
  logic stepDone, lockOk, busy;
  logic signed [CNT_W-1:0] stepCount;
  logic signed [PS_W-1:0]  offsetPs;

  fine_phase_port u_fine_phase_port (
    .clk(clk), .rst(rst), .stepReq(stepReq), .stepUp(stepUp),
    .stepDone(stepDone), .lockOk(lockOk), .busy(busy),
    .stepCount(stepCount), .offsetPs(offsetPs)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  int model  = 0;

  typedef struct {
    int dueCyc;
    int cnt;
  } exp_t;
  exp_t expQ[$];

  task automatic cmpInt(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: every done pulse must match the head of the queue.
  exp_t e;
  always @(negedge clk) begin
    if (!rst && stepDone) begin
      if (expQ.size() == 0) begin
        cmpInt("R7", "unexpected done", 1, 0);
      end else begin
        e = expQ.pop_front();
        cmpInt("R4", "done cycle", cyc, e.dueCyc);
        cmpInt("R5", "count at done", int'(stepCount), e.cnt);
        cmpInt("R9", "offset at done", int'(offsetPs), e.cnt * UNIT);
      end
    end
  end

  task automatic waitTo(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Driver: one-cycle request; pushes an expected item when a done is due.
  task automatic request(bit up, bit expectDone);
    stepReq = 1'b1;
    stepUp  = up;
    if (expectDone) begin
      if (up && model < CMAX) model++;
      else if (!up && model > CMIN) model--;
      expQ.push_back('{cyc + LAT, model});
    end
    @(negedge clk);
    stepReq = 1'b0;
  endtask

  task automatic stepAndWait(bit up);
    int k;
    k = cyc;
    request(up, 1'b1);
    waitTo(k + LAT + 1);
  endtask

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finishRun();
  end

  initial begin
    int rel, k;
    repeat (3) @(negedge clk);
    // R1 reset state
    cmpInt("R1", "lockOk in reset", lockOk, 0);
    cmpInt("R1", "busy in reset", busy, 0);
    cmpInt("R1", "done in reset", stepDone, 0);
    cmpInt("R1", "count in reset", int'(stepCount), 0);
    cmpInt("R1", "offset in reset", int'(offsetPs), 0);

    rst = 1'b0;
    rel = cyc;
    // R3: request before lock is ignored
    waitTo(rel + 5);
    request(1'b1, 1'b0);
    cmpInt("R3", "busy after unlocked req", busy, 0);
    // R2: lock timing
    waitTo(rel + SETTLE - 1);
    cmpInt("R2", "lock one cycle early", lockOk, 0);
    waitTo(rel + SETTLE);
    cmpInt("R2", "lock on time", lockOk, 1);
    cmpInt("R3", "count after unlocked req", int'(stepCount), 0);

    // R5/R6: basic up step with busy window
    k = cyc;
    request(1'b1, 1'b1);
    cmpInt("R6", "busy after accept", busy, 1);
    waitTo(k + LAT);
    cmpInt("R6", "busy in done cycle", busy, 1);
    waitTo(k + LAT + 1);
    cmpInt("R6", "busy after done", busy, 0);
    cmpInt("R2", "lock still high", lockOk, 1);

    // Down steps, back to back
    stepAndWait(1'b0);
    stepAndWait(1'b0);
    cmpInt("R5", "count after downs", int'(stepCount), -1);
    cmpInt("R9", "offset after downs", int'(offsetPs), -18);

    // R7: early pulse and done-cycle pulse dropped, latency not restarted
    k = cyc;
    request(1'b1, 1'b1);
    waitTo(k + 5);
    request(1'b0, 1'b0);
    waitTo(k + LAT);
    request(1'b0, 1'b0);
    cmpInt("R7", "busy after done-cycle pulse", busy, 0);
    waitTo(k + LAT + 20);
    cmpInt("R7", "count after dropped pulses", int'(stepCount), 0);

    // R5: direction sampled only at acceptance
    k = cyc;
    request(1'b0, 1'b1);
    stepUp = 1'b1;
    waitTo(k + LAT + 1);
    stepUp = 1'b0;
    cmpInt("R5", "direction held", int'(stepCount), -1);

    // R8: saturate high
    while (model < CMAX) stepAndWait(1'b1);
    stepAndWait(1'b1);
    cmpInt("R8", "saturate high", int'(stepCount), CMAX);
    cmpInt("R9", "offset at high limit", int'(offsetPs), 18414);
    // R8: saturate low
    while (model > CMIN) stepAndWait(1'b0);
    stepAndWait(1'b0);
    cmpInt("R8", "saturate low", int'(stepCount), CMIN);
    cmpInt("R9", "offset at low limit", int'(offsetPs), -18432);

    // R1: reset cancels a pending step
    k = cyc;
    request(1'b1, 1'b0);
    waitTo(k + 4);
    cmpInt("R1", "pending before reset", busy, 1);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    model = 0;
    cmpInt("R1", "count after reset", int'(stepCount), 0);
    cmpInt("R1", "lock dropped", lockOk, 0);
    cmpInt("R1", "busy cleared", busy, 0);
    rst = 1'b0;
    rel = cyc;
    waitTo(rel + SETTLE + 10);
    cmpInt("R2", "relock", lockOk, 1);
    stepAndWait(1'b1);
    cmpInt("R5", "step after reset", int'(stepCount), 1);

    repeat (5) @(negedge clk);
    cmpInt("R4", "outstanding dones", expQ.size(), 0);
    finishRun();
  end

endmodule